// File: doc/BRIEF.md
# Cascaded System Clock Prescaler

This block turns one system clock into three nested rate domains without deriving any new clock. It issues three clock-enable strobes, each one system clock cycle wide. The fast peripheral strobe comes from a power-of-two divider on the system clock. The half-rate peripheral strobe is a further division of the fast one by 1, 2 or 4. The CPU strobe is a further division of the half-rate one by 1 or 2. With the two downstream dividers at 1, all three strobes run at the first divider's rate. Other settings let the peripheral logic run at two or four times the CPU rate. Logic in each domain advances only in cycles where its strobe is high.

Ratios are set through a write-only register port with three addresses. Writes to the two ratio registers are honoured only inside a short window. A correct key written to a separate address opens that window. A new ratio is first held as pending. It becomes active only in the cycle where all three divider counters wrap together, so no strobe period is cut short or stretched at the moment of change.

Top module: `clk_ratio_chain`

## Requirements
- R1: After reset every divider is at 1 and the write window is closed, so all three strobes are high in every cycle.
- R2: Address 1, bits [3:0], holds an exponent n from 0 to 9. The fast strobe then has a period of 2^n system cycles.
- R3: Exponent codes 10 to 15 at address 1 are treated as n = 0, a period of 1.
- R4: Address 2, bits [1:0], sets the half-rate divider: 0 gives /1, 1 gives /2, 2 gives /4, and the reserved code 3 gives /1.
- R5: Address 2, bit 2, sets the CPU divider: 0 gives /1 and 1 gives /2.
- R6: Each strobe is high for one cycle per period of its domain. The CPU strobe is high only in cycles where the half-rate strobe is high, and the half-rate strobe only where the fast strobe is high.
- R7: Writing the key 8'hA7 to address 0 opens a window. Ratio writes that land on any of the next four clock edges are accepted. A ratio write on the fifth edge or later is ignored.
- R8: A ratio write made while no window is open has no effect. This includes writes after a wrong key value.
- R9: The window closes as soon as one ratio write is accepted. A second ratio write in the remaining window cycles is ignored.
- R10: An accepted setting takes effect only in a cycle where the CPU strobe is high, when all three counters wrap. Across the change, every fast-strobe gap equals either the old period or the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 key, 1 first divider, 2 downstream dividers |
| wrData | input | 8 | Register write data |
| per4En | output | 1 | Fast peripheral clock enable |
| per2En | output | 1 | Half-rate peripheral clock enable |
| cpuEn | output | 1 | CPU clock enable |

## Verification
Several properties are checked on every cycle. The strobes must nest. A fast strobe must not repeat in the next cycle unless the counters wrap. The active ratios may change only in a wrap cycle. The window may not open without a key and must close after an accepted write. The periods each ratio code produces are shown only by the bench's scenarios. So are the reserved codes, the exact edge where the window ends, rejected writes, and the absence of odd gaps across a ratio change. The bench shows these by measuring strobe gaps at the ports.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam logic [1:0] ADDR_KEY = 2'd0;
  localparam logic [1:0] ADDR_A   = 2'd1;
  localparam logic [1:0] ADDR_BC  = 2'd2;

  typedef struct packed {
    logic       ldA;
    logic       ldBC;
    logic [7:0] val;
  } ratioWr_t;
endpackage

// File: rtl/ratio_guard.sv
module ratio_guard
  import clk_ratio_pkg::*;
#(
  parameter logic [7:0] KEY_VAL = 8'hA7,
  parameter int         WINDOW  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output ratioWr_t   wrStb
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] winCnt;
  logic             keyHit;
  logic             winOpen;
  logic             accept;

  assign keyHit  = wrEn && (wrAddr == ADDR_KEY) && (wrData == KEY_VAL);
  assign winOpen = (winCnt != '0);

  always_comb begin
    wrStb.ldA  = wrEn && winOpen && (wrAddr == ADDR_A);
    wrStb.ldBC = wrEn && winOpen && (wrAddr == ADDR_BC);
    wrStb.val  = wrData;
  end
  assign accept = wrStb.ldA || wrStb.ldBC;

  always_ff @(posedge clk) begin
    if (!rstN)            winCnt <= '0;
    else if (keyHit)      winCnt <= WIN_W'(WINDOW);
    else if (accept)      winCnt <= '0;
    else if (winOpen)     winCnt <= winCnt - 1'b1;
  end

  // R8: without a key the window stays shut
  p_closed_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!keyHit && !winOpen) |=> !winOpen);
  // R9: an accepted write closes the window at once
  p_accept_closes_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !winOpen);
  // R7: window length never exceeds its bound
  p_window_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_W'(WINDOW));
endmodule

// File: rtl/ratio_chain.sv
module ratio_chain
  import clk_ratio_pkg::*;
#(
  parameter int A_EXP_MAX = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  ratioWr_t wrStb,
  output logic     per4En,
  output logic     per2En,
  output logic     cpuEn
);
  localparam int CNT_A_W = (A_EXP_MAX < 1) ? 1 : A_EXP_MAX;
  localparam int EXP_W   = 4;

  logic [EXP_W-1:0]   pendA, actA;
  logic [1:0]         pendB, actB;
  logic               pendC, actC;
  logic [CNT_A_W-1:0] cntA, maxA;
  logic [1:0]         cntB, maxB;
  logic               cntC;
  logic [EXP_W-1:0]   codeA;
  logic [1:0]         codeB;

  assign codeA = (wrStb.val[EXP_W-1:0] > EXP_W'(A_EXP_MAX)) ? '0 : wrStb.val[EXP_W-1:0];
  assign codeB = (wrStb.val[1:0] == 2'd3) ? 2'd0 : wrStb.val[1:0];

  assign maxA = ~({CNT_A_W{1'b1}} << actA);
  assign maxB = ~(2'b11 << actB);

  assign per4En = (cntA == maxA);
  assign per2En = per4En && (cntB == maxB);
  assign cpuEn  = per2En && (cntC == actC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendA <= '0;
      pendB <= '0;
      pendC <= 1'b0;
    end else begin
      if (wrStb.ldA) pendA <= codeA;
      if (wrStb.ldBC) begin
        pendB <= codeB;
        pendC <= wrStb.val[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actA <= '0;
      actB <= '0;
      actC <= 1'b0;
      cntA <= '0;
      cntB <= '0;
      cntC <= 1'b0;
    end else begin
      cntA <= per4En ? '0 : cntA + 1'b1;
      if (per4En) cntB <= per2En ? 2'd0 : cntB + 1'b1;
      if (per2En) cntC <= cpuEn ? 1'b0 : ~cntC;
      if (cpuEn) begin
        actA <= pendA;
        actB <= pendB;
        actC <= pendC;
      end
    end
  end

  // R6: strobes nest
  p_cpu_in_per2_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |-> (per2En && per4En));
  // R6: a divided fast strobe lasts one cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (per4En && !cpuEn && actA != '0) |=> !per4En);
  // R10: active ratios move only at the common wrap
  p_apply_at_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cpuEn |=> ($stable(actA) && $stable(actB) && $stable(actC)));
endmodule

// File: rtl/clk_ratio_chain.sv
module clk_ratio_chain
  import clk_ratio_pkg::*;
#(
  parameter logic [7:0] KEY_VAL   = 8'hA7,
  parameter int         WINDOW    = 4,
  parameter int         A_EXP_MAX = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       per4En,
  output logic       per2En,
  output logic       cpuEn
);
  ratioWr_t wrStb;

  ratio_guard #(.KEY_VAL(KEY_VAL), .WINDOW(WINDOW)) u_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrStb(wrStb)
  );

  ratio_chain #(.A_EXP_MAX(A_EXP_MAX)) u_chain (
    .clk(clk), .rstN(rstN), .wrStb(wrStb),
    .per4En(per4En), .per2En(per2En), .cpuEn(cpuEn)
  );
endmodule

// File: tb/clk_ratio_chain_bench.sv
module clk_ratio_chain_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       per4En, per2En, cpuEn;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  clk_ratio_chain u_clk_ratio_chain (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .per4En(per4En), .per2En(per2En), .cpuEn(cpuEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? per4En : (sel == 1) ? per2En : cpuEn;
  endfunction

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlockWr(input logic [1:0] a, input logic [7:0] d);
    busWr(2'd0, 8'hA7);
    busWr(a, d);
  endtask

  task automatic settle();
    repeat (4200) @(negedge clk);
  endtask

  task automatic gapOf(input int sel, output int g);
    int guard = 0;
    g = 0;
    @(negedge clk);
    while (!pick(sel) && guard < 5000) begin @(negedge clk); guard++; end
    do begin @(negedge clk); g++; end while (!pick(sel) && g < 5000);
  endtask

  task automatic checkPeriods(input int pa, input int pb, input int pc, input string req);
    int g;
    gapOf(0, g); chk(g == pa, {req, " per4"}, g, pa);
    gapOf(1, g); chk(g == pa * pb, {req, " per2"}, g, pa * pb);
    gapOf(2, g); chk(g == pa * pb * pc, {req, " cpu"}, g, pa * pb * pc);
  endtask

  task automatic t_reset();
    int hits = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (per4En && per2En && cpuEn) hits++;
    end
    chk(hits == 8, "R1 all strobes every cycle", hits, 8);
  endtask

  task automatic t_ratios();
    unlockWr(2'd1, 8'd3);
    unlockWr(2'd2, 8'b110);   // R4 /4, R5 /2
    settle();
    checkPeriods(8, 4, 2, "R2 R4 R5 a3 b4 c2");
    unlockWr(2'd1, 8'd9);
    unlockWr(2'd2, 8'b001);
    settle();
    checkPeriods(512, 2, 1, "R2 R4 a9 b2 c1");
  endtask

  task automatic t_reserved();
    unlockWr(2'd1, 8'd12);   // R3
    unlockWr(2'd2, 8'b011);  // R4 reserved code
    settle();
    checkPeriods(1, 1, 1, "R3 R4 reserved codes");
  endtask

  task automatic t_window();
    unlockWr(2'd1, 8'd1);
    unlockWr(2'd2, 8'd0);
    settle();
    busWr(2'd1, 8'd5);                 // R8 no key
    settle();
    checkPeriods(2, 1, 1, "R8 write without key");
    busWr(2'd0, 8'h5B);                // R8 wrong key
    busWr(2'd1, 8'd5);
    settle();
    checkPeriods(2, 1, 1, "R8 wrong key");
    busWr(2'd0, 8'hA7);                // R7 fifth edge
    repeat (3) @(negedge clk);
    busWr(2'd1, 8'd5);
    settle();
    checkPeriods(2, 1, 1, "R7 write after window");
    busWr(2'd0, 8'hA7);                // R7 fourth edge
    repeat (2) @(negedge clk);
    busWr(2'd1, 8'd2);
    settle();
    checkPeriods(4, 1, 1, "R7 last window edge");
    busWr(2'd0, 8'hA7);                // R9 second write rejected
    busWr(2'd1, 8'd1);
    busWr(2'd2, 8'b110);
    settle();
    checkPeriods(2, 1, 1, "R9 window closes");
  endtask

  task automatic t_wrap();
    int g;
    int odd = 0;
    unlockWr(2'd1, 8'd2);
    unlockWr(2'd2, 8'd1);
    settle();
    repeat (3) @(negedge clk);
    unlockWr(2'd1, 8'd4);
    for (int i = 0; i < 6; i++) begin
      gapOf(0, g);
      if (g != 4 && g != 16) odd++;
    end
    chk(odd == 0, "R10 no odd gap at change", odd, 0);
    chk(g == 16, "R10 new period applied", g, 16);
  endtask

  task automatic t_nesting();
    int bad = 0;
    int cpuCnt = 0;
    int per2Cnt = 0;
    unlockWr(2'd1, 8'd1);
    unlockWr(2'd2, 8'b110);
    settle();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if ((cpuEn && !per2En) || (per2En && !per4En)) bad++;
      if (cpuEn) cpuCnt++;
      if (per2En) per2Cnt++;
    end
    chk(bad == 0, "R6 nesting", bad, 0);
    chk(cpuCnt == 16, "R6 cpu count", cpuCnt, 16);
    chk(per2Cnt == 32, "R6 per2 count", per2Cnt, 32);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ratios();
    t_reserved();
    t_window();
    t_wrap();
    t_nesting();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule